// File: doc/BRIEF.md
# Clock-Group Stop Controller

This block produces three groups of gated clock outputs (processor, peripheral bus and memory) from one fast reference clock, dividing the reference by an even ratio per group. Each group can be halted on request for low-power operation. The request pins are asynchronous and active low. They only take effect when the mobile-mode input is high. An active-low power-down input silences every output, and a per-output enable bit can hold any single output quiet.

Every output is a register in the reference domain. It only goes high at the start of a group period and only goes low at mid-period. A halted output therefore rests at logic 0, and the first high phase after a restart is always full width. Each group has its own pipeline depth between the synchronized request and its gate, and its own minimum number of pulses after each restart. One peripheral-bus output is free-running and ignores its group's stop request.

Top module: `cgs_clock_stop_ctrl`

## Requirements
- R1: While running, each output toggles with period 2*HALF reference cycles (processor HALF=2, peripheral HALF=6, memory HALF=2).
- R2: Every high phase on any output lasts exactly HALF reference cycles; a halted output is held at 0.
- R3: After a stop request is asserted (mobile mode, minimum run satisfied), a group delivers between LAT and LAT+1 further rising edges and then stays low; LAT is 2 for the processor group (fewer than 4 cycles), 0 for the peripheral group, 1 for the memory group.
- R4: After a stop request is released, the group's first rising edge comes within 2 + (LAT+1)*2*HALF reference cycles.
- R5: After each restart, a group delivers at least MIN pulses before it stops again (processor 100, peripheral 10, memory 10). A request that drops out briefly restarts the group for exactly MIN pulses.
- R6: With mobile_mode at 0, stop requests have no effect and all groups run.
- R7: Peripheral output bit 0 is free-running: the peripheral stop request never halts it.
- R8: Power-down low takes every output, free-running one included, to 0 by its group's next falling edge after the 2-stage synchronizer. No output rises while it is held, whatever the stop requests do.
- R9: An enable bit of 0 keeps its output at 0 from the next period start on, while the other outputs keep running.
- R10: While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mobile_mode | input | 1 | 1 lets stop requests act, 0 ignores them |
| cpu_stop_n | input | 1 | Asynchronous stop request, processor group, active low |
| pci_stop_n | input | 1 | Asynchronous stop request, peripheral group, active low |
| sdr_stop_n | input | 1 | Asynchronous stop request, memory group, active low |
| pwrdn_n | input | 1 | Asynchronous power-down, active low |
| cpu_en | input | 3 | Per-output enable, processor group |
| pci_en | input | 6 | Per-output enable, peripheral group (bit 0 free-running) |
| sdr_en | input | 13 | Per-output enable, memory group |
| cpu_clk | output | 3 | Processor group clocks |
| pci_clk | output | 6 | Peripheral group clocks |
| sdr_clk | output | 13 | Memory group clocks |

## Verification
The bench counts the rising edges after a stop, to show that each group honours its own pipeline depth. A design with the wrong depth would let one pulse too many through, or stop one too early. It gives a stopped group a request that drops out for a single period. A group that skips the minimum-run count would stop after a handful of pulses instead of exactly MIN. It measures every high phase on every output. A gate that changes mid-phase, or on power-down, would leave a runt pulse. It also checks that the free-running output keeps toggling under its group's stop request, and that mode 0 masks every request.

// File: rtl/cgs_pkg.sv
package cgs_pkg;

  typedef enum logic {
    GRP_PARKED  = 1'b0,
    GRP_RUNNING = 1'b1
  } grp_state_e;

  // Bits needed to hold values 0..maxval.
  function automatic int unsigned cnt_width(input int unsigned maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/cgs_sync.sv
module cgs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      sr_d[i] = sr_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= {STAGES{RST_VAL}};
    end else begin
      sr_q <= sr_d;
    end
  end

  assign q = sr_q[STAGES-1];

endmodule

// File: rtl/cgs_divider.sv
module cgs_divider
  import cgs_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rise_tick,
  output logic fall_tick,
  output logic phase
);

  localparam int CW = cnt_width(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  always_comb begin
    wrap      = (cnt_q == CW'(HALF - 1));
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    ph_d      = wrap ? ~ph_q : ph_q;
    rise_tick = wrap & ~ph_q;
    fall_tick = wrap & ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign phase = ph_q;

endmodule

// File: rtl/cgs_group.sv
module cgs_group
  import cgs_pkg::*;
#(
  parameter int               WIDTH     = 3,
  parameter logic [WIDTH-1:0] FREE_MASK = '0,
  parameter int               LAT       = 2,
  parameter int               MIN_RUN   = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_tick,
  input  logic             fall_tick,
  input  logic             req,
  input  logic             pd,
  input  logic [WIDTH-1:0] en,
  output logic [WIDTH-1:0] clk_out
);

  localparam int RW = cnt_width(MIN_RUN);

  logic       req_seen;
  grp_state_e state_q, state_d;
  logic [RW-1:0] run_cnt_q, run_cnt_d;

  // Request pipeline, advanced once per group period.
  generate
    if (LAT == 0) begin : g_direct
      assign req_seen = req;
    end else begin : g_pipe
      logic [LAT-1:0] pipe_q, pipe_d;

      always_comb begin
        pipe_d = pipe_q;
        if (rise_tick) begin
          pipe_d[0] = req;
          for (int i = 1; i < LAT; i++) begin
            pipe_d[i] = pipe_q[i-1];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pipe_q <= '0;
        end else begin
          pipe_q <= pipe_d;
        end
      end

      assign req_seen = pipe_q[LAT-1];
    end
  endgenerate

  // Run state and minimum-run counter, decided at each period start.
  always_comb begin
    state_d   = state_q;
    run_cnt_d = run_cnt_q;
    if (rise_tick) begin
      if (pd) begin
        state_d   = GRP_PARKED;
        run_cnt_d = '0;
      end else if (state_q == GRP_RUNNING) begin
        if (req_seen && (run_cnt_q >= RW'(MIN_RUN))) begin
          state_d = GRP_PARKED;
        end else if (run_cnt_q < RW'(MIN_RUN)) begin
          run_cnt_d = run_cnt_q + 1'b1;
        end
      end else if (!req_seen) begin
        state_d   = GRP_RUNNING;
        run_cnt_d = RW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= GRP_PARKED;
      run_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      run_cnt_q <= run_cnt_d;
    end
  end

  // One output register per pin: set only at period start, cleared at mid-period.
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic allow;
      logic out_q, out_d;

      if (FREE_MASK[b]) begin : g_free
        assign allow = ~pd;
      end else begin : g_gated
        assign allow = (state_d == GRP_RUNNING);
      end

      always_comb begin
        out_d = out_q;
        if (rise_tick) begin
          out_d = allow & en[b];
        end else if (fall_tick) begin
          out_d = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_q <= 1'b0;
        end else begin
          out_q <= out_d;
        end
      end

      assign clk_out[b] = out_q;
    end
  endgenerate

endmodule

// File: rtl/cgs_clock_stop_ctrl.sv
module cgs_clock_stop_ctrl #(
  parameter int                CPU_W         = 3,
  parameter int                PCI_W         = 6,
  parameter int                SDR_W         = 13,
  parameter int                CPU_HALF      = 2,
  parameter int                PCI_HALF      = 6,
  parameter int                SDR_HALF      = 2,
  parameter int                CPU_LAT       = 2,
  parameter int                PCI_LAT       = 0,
  parameter int                SDR_LAT       = 1,
  parameter int                CPU_MIN       = 100,
  parameter int                PCI_MIN       = 10,
  parameter int                SDR_MIN       = 10,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [PCI_W-1:0]  PCI_FREE_MASK = PCI_W'(1)
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             mobile_mode,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             sdr_stop_n,
  input  logic             pwrdn_n,
  input  logic [CPU_W-1:0] cpu_en,
  input  logic [PCI_W-1:0] pci_en,
  input  logic [SDR_W-1:0] sdr_en,
  output logic [CPU_W-1:0] cpu_clk,
  output logic [PCI_W-1:0] pci_clk,
  output logic [SDR_W-1:0] sdr_clk
);

  logic rst_int_n;
  logic pd_sync;
  logic cpu_req_s, pci_req_s, sdr_req_s;
  logic cpu_rise, cpu_fall, cpu_ph;
  logic pci_rise, pci_fall, pci_ph;
  logic sdr_rise, sdr_fall, sdr_ph;

  // Reset: asserted at once, released on the clock.
  cgs_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk_ref), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  // Request qualification by mode, then synchronization.
  cgs_sync #(.STAGES(SYNC_STAGES)) u_cpu_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(mobile_mode & ~cpu_stop_n), .q(cpu_req_s)
  );
  cgs_sync #(.STAGES(SYNC_STAGES)) u_pci_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(mobile_mode & ~pci_stop_n), .q(pci_req_s)
  );
  cgs_sync #(.STAGES(SYNC_STAGES)) u_sdr_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(mobile_mode & ~sdr_stop_n), .q(sdr_req_s)
  );
  cgs_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk(clk_ref), .rst_n(rst_int_n), .d(~pwrdn_n), .q(pd_sync)
  );

  // Group timebases.
  cgs_divider #(.HALF(CPU_HALF)) u_cpu_div (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(cpu_rise), .fall_tick(cpu_fall), .phase(cpu_ph)
  );
  cgs_divider #(.HALF(PCI_HALF)) u_pci_div (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(pci_rise), .fall_tick(pci_fall), .phase(pci_ph)
  );
  cgs_divider #(.HALF(SDR_HALF)) u_sdr_div (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(sdr_rise), .fall_tick(sdr_fall), .phase(sdr_ph)
  );

  // Group gating.
  cgs_group #(
    .WIDTH(CPU_W), .FREE_MASK('0), .LAT(CPU_LAT), .MIN_RUN(CPU_MIN)
  ) u_cpu_grp (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(cpu_rise), .fall_tick(cpu_fall),
    .req(cpu_req_s), .pd(pd_sync), .en(cpu_en), .clk_out(cpu_clk)
  );
  cgs_group #(
    .WIDTH(PCI_W), .FREE_MASK(PCI_FREE_MASK), .LAT(PCI_LAT), .MIN_RUN(PCI_MIN)
  ) u_pci_grp (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(pci_rise), .fall_tick(pci_fall),
    .req(pci_req_s), .pd(pd_sync), .en(pci_en), .clk_out(pci_clk)
  );
  cgs_group #(
    .WIDTH(SDR_W), .FREE_MASK('0), .LAT(SDR_LAT), .MIN_RUN(SDR_MIN)
  ) u_sdr_grp (
    .clk(clk_ref), .rst_n(rst_int_n), .rise_tick(sdr_rise), .fall_tick(sdr_fall),
    .req(sdr_req_s), .pd(pd_sync), .en(sdr_en), .clk_out(sdr_clk)
  );

endmodule

// File: rtl/cgs_checker.sv
module cgs_checker #(
  parameter int               CPU_W         = 3,
  parameter int               PCI_W         = 6,
  parameter int               SDR_W         = 13,
  parameter logic [PCI_W-1:0] PCI_FREE_MASK = PCI_W'(1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_s,
  input logic             cpu_rise,
  input logic             cpu_ph,
  input logic             pci_rise,
  input logic             pci_ph,
  input logic             sdr_rise,
  input logic             sdr_ph,
  input logic [CPU_W-1:0] cpu_en,
  input logic [PCI_W-1:0] pci_en,
  input logic [SDR_W-1:0] sdr_en,
  input logic [CPU_W-1:0] cpu_clk,
  input logic [PCI_W-1:0] pci_clk,
  input logic [SDR_W-1:0] sdr_clk
);

  // Outputs are high only inside the high half of their timebase.
  p_park_low_r2_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk != '0) |-> cpu_ph);
  p_park_low_r2_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_clk != '0) |-> pci_ph);
  p_park_low_r2_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    (sdr_clk != '0) |-> sdr_ph);

  // No period starts while power-down is seen.
  p_pd_quiet_r8_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_s && cpu_rise) |=> (cpu_clk == '0));
  p_pd_quiet_r8_pci: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_s && pci_rise) |=> (pci_clk == '0));
  p_pd_quiet_r8_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_s && sdr_rise) |=> (sdr_clk == '0));

  // Disabled pins stay low across a period start.
  p_en_hold_r9_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rise |=> ((cpu_clk & ~$past(cpu_en)) == '0));
  p_en_hold_r9_pci: assert property (@(posedge clk) disable iff (!rst_n)
    pci_rise |=> ((pci_clk & ~$past(pci_en)) == '0));
  p_en_hold_r9_sdr: assert property (@(posedge clk) disable iff (!rst_n)
    sdr_rise |=> ((sdr_clk & ~$past(sdr_en)) == '0));

  // Free-running pins start every period when enabled and not powered down.
  p_free_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_rise && !pd_s) |=>
      ((pci_clk & PCI_FREE_MASK & $past(pci_en)) == (PCI_FREE_MASK & $past(pci_en))));

endmodule

bind cgs_clock_stop_ctrl cgs_checker #(
  .CPU_W(CPU_W), .PCI_W(PCI_W), .SDR_W(SDR_W), .PCI_FREE_MASK(PCI_FREE_MASK)
) u_chk (
  .clk(clk_ref), .rst_n(rst_int_n), .pd_s(pd_sync),
  .cpu_rise(cpu_rise), .cpu_ph(cpu_ph),
  .pci_rise(pci_rise), .pci_ph(pci_ph),
  .sdr_rise(sdr_rise), .sdr_ph(sdr_ph),
  .cpu_en(cpu_en), .pci_en(pci_en), .sdr_en(sdr_en),
  .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk)
);

// File: tb/sim_cgs_clock_stop_ctrl.sv
`timescale 1ns/1ps
module sim_cgs_clock_stop_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CPU_W = 3, PCI_W = 6, SDR_W = 13;
  localparam int CPU_HALF = 2, PCI_HALF = 6, SDR_HALF = 2;
  localparam int CPU_LAT = 2, PCI_LAT = 0, SDR_LAT = 1;
  localparam int CPU_MIN = 100, PCI_MIN = 10, SDR_MIN = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mobile_mode = 1'b1;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, sdr_stop_n = 1'b1;
  logic pwrdn_n = 1'b1;
  logic [CPU_W-1:0] cpu_en = '1;
  logic [PCI_W-1:0] pci_en = '1;
  logic [SDR_W-1:0] sdr_en = '1;
  logic [CPU_W-1:0] cpu_clk;
  logic [PCI_W-1:0] pci_clk;
  logic [SDR_W-1:0] sdr_clk;

  int checks = 0;
  int errors = 0;

  int cpu_rc[CPU_W], pci_rc[PCI_W], sdr_rc[SDR_W];
  int cpu_hw[CPU_W], pci_hw[PCI_W], sdr_hw[SDR_W];
  logic [CPU_W-1:0] cpu_prev = '0;
  logic [PCI_W-1:0] pci_prev = '0;
  logic [SDR_W-1:0] sdr_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cgs_clock_stop_ctrl u0 (
    .clk_ref(clk), .rst_n(rst_n), .mobile_mode(mobile_mode),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .sdr_stop_n(sdr_stop_n),
    .pwrdn_n(pwrdn_n), .cpu_en(cpu_en), .pci_en(pci_en), .sdr_en(sdr_en),
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_rises(input int win, input int half);
    return win / (2 * half);
  endfunction

  function automatic int restart_bound(input int lat, input int half);
    return SYNC + (lat + 1) * 2 * half;
  endfunction

  function automatic bit exp_run(input bit mode, input bit stop_n, input bit pd_n);
    return pd_n && (!mode || stop_n);
  endfunction

  // Edge counting and high-phase width measurement, sampled at falling edges.
  always @(negedge clk) begin
    for (int i = 0; i < CPU_W; i++) begin
      if (cpu_clk[i] === 1'b1) begin
        cpu_hw[i]++;
        if (cpu_prev[i] !== 1'b1) cpu_rc[i]++;
      end else if (cpu_prev[i] === 1'b1) begin
        chk(cpu_hw[i] == CPU_HALF, "R2 cpu high phase width", cpu_hw[i], CPU_HALF);
        cpu_hw[i] = 0;
      end
    end
    for (int i = 0; i < PCI_W; i++) begin
      if (pci_clk[i] === 1'b1) begin
        pci_hw[i]++;
        if (pci_prev[i] !== 1'b1) pci_rc[i]++;
      end else if (pci_prev[i] === 1'b1) begin
        chk(pci_hw[i] == PCI_HALF, "R2 pci high phase width", pci_hw[i], PCI_HALF);
        pci_hw[i] = 0;
      end
    end
    for (int i = 0; i < SDR_W; i++) begin
      if (sdr_clk[i] === 1'b1) begin
        sdr_hw[i]++;
        if (sdr_prev[i] !== 1'b1) sdr_rc[i]++;
      end else if (sdr_prev[i] === 1'b1) begin
        chk(sdr_hw[i] == SDR_HALF, "R2 sdram high phase width", sdr_hw[i], SDR_HALF);
        sdr_hw[i] = 0;
      end
    end
    cpu_prev = cpu_clk;
    pci_prev = pci_clk;
    sdr_prev = sdr_clk;
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic clear_counts();
    foreach (cpu_rc[i]) cpu_rc[i] = 0;
    foreach (pci_rc[i]) pci_rc[i] = 0;
    foreach (sdr_rc[i]) sdr_rc[i] = 0;
  endtask

  function automatic int total_rises();
    int s = 0;
    foreach (cpu_rc[i]) s += cpu_rc[i];
    foreach (pci_rc[i]) s += pci_rc[i];
    foreach (sdr_rc[i]) s += sdr_rc[i];
    return s;
  endfunction

  initial begin
    foreach (cpu_hw[i]) cpu_hw[i] = 0;
    foreach (pci_hw[i]) pci_hw[i] = 0;
    foreach (sdr_hw[i]) sdr_hw[i] = 0;
    clear_counts();
  end

  // Watchdog.
  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c;
    bit m, s_c, s_p, s_s, p;
    void'($urandom(32'd4711));

    // R10: outputs low during reset.
    step(6);
    chk((cpu_clk == '0) && (pci_clk == '0) && (sdr_clk == '0), "R10 reset outputs",
        int'(cpu_clk) + int'(pci_clk) + int'(sdr_clk), 0);
    rst_n = 1'b1;
    step(450);

    // R1: division ratios on every pin.
    clear_counts();
    step(240);
    for (int i = 0; i < CPU_W; i++)
      chk(cpu_rc[i] == exp_rises(240, CPU_HALF), "R1 cpu rise count", cpu_rc[i], exp_rises(240, CPU_HALF));
    for (int i = 0; i < PCI_W; i++)
      chk(pci_rc[i] == exp_rises(240, PCI_HALF), "R1 pci rise count", pci_rc[i], exp_rises(240, PCI_HALF));
    for (int i = 0; i < SDR_W; i++)
      chk(sdr_rc[i] == exp_rises(240, SDR_HALF), "R1 sdram rise count", sdr_rc[i], exp_rises(240, SDR_HALF));

    // R3: processor stop latency; other groups unaffected.
    cpu_stop_n = 1'b0;
    clear_counts();
    step(40);
    chk(cpu_rc[0] >= CPU_LAT && cpu_rc[0] <= CPU_LAT + 1, "R3 cpu edges after stop", cpu_rc[0], CPU_LAT + 1);
    chk(cpu_rc[0] < 4, "R3 cpu stop under 4 cycles", cpu_rc[0], 3);
    chk(sdr_rc[0] == exp_rises(40, SDR_HALF), "R3 sdram keeps running", sdr_rc[0], exp_rises(40, SDR_HALF));
    clear_counts();
    step(100);
    chk(cpu_rc[0] == 0 && cpu_clk == '0, "R2 cpu parked low", cpu_rc[0], 0);

    // R4: processor restart latency.
    cpu_stop_n = 1'b1;
    c = 0;
    while (cpu_clk[0] !== 1'b1 && c < 100) begin
      step(1);
      c++;
    end
    chk(c <= restart_bound(CPU_LAT, CPU_HALF), "R4 cpu restart latency", c, restart_bound(CPU_LAT, CPU_HALF));

    // R5: processor minimum run after a brief release.
    step(450);
    cpu_stop_n = 1'b0;
    step(60);
    clear_counts();
    cpu_stop_n = 1'b1;
    step(2 * CPU_HALF);
    cpu_stop_n = 1'b0;
    step(600);
    chk(cpu_rc[0] == CPU_MIN, "R5 cpu minimum run", cpu_rc[0], CPU_MIN);

    // R3 and R7: peripheral stop, free-running pin.
    pci_stop_n = 1'b0;
    clear_counts();
    step(40);
    chk(pci_rc[1] >= PCI_LAT && pci_rc[1] <= PCI_LAT + 1, "R3 pci edges after stop", pci_rc[1], PCI_LAT + 1);
    chk(pci_clk[PCI_W-1:1] == '0, "R3 pci stopped pins low", int'(pci_clk), 0);
    clear_counts();
    step(120);
    chk(pci_rc[0] == exp_rises(120, PCI_HALF), "R7 free-running pci pin", pci_rc[0], exp_rises(120, PCI_HALF));
    chk(pci_rc[1] == 0, "R2 pci parked low", pci_rc[1], 0);

    // R4: peripheral restart latency.
    pci_stop_n = 1'b1;
    c = 0;
    while (pci_clk[1] !== 1'b1 && c < 100) begin
      step(1);
      c++;
    end
    chk(c <= restart_bound(PCI_LAT, PCI_HALF), "R4 pci restart latency", c, restart_bound(PCI_LAT, PCI_HALF));

    // R5: peripheral minimum run.
    step(200);
    pci_stop_n = 1'b0;
    step(60);
    clear_counts();
    pci_stop_n = 1'b1;
    step(2 * PCI_HALF);
    pci_stop_n = 1'b0;
    step(300);
    chk(pci_rc[1] == PCI_MIN, "R5 pci minimum run", pci_rc[1], PCI_MIN);

    // R3, R4, R5: memory group.
    sdr_stop_n = 1'b0;
    clear_counts();
    step(40);
    chk(sdr_rc[0] >= SDR_LAT && sdr_rc[0] <= SDR_LAT + 1, "R3 sdram edges after stop", sdr_rc[0], SDR_LAT + 1);
    chk(sdr_clk == '0, "R2 sdram parked low", int'(sdr_clk), 0);
    sdr_stop_n = 1'b1;
    c = 0;
    while (sdr_clk[0] !== 1'b1 && c < 100) begin
      step(1);
      c++;
    end
    chk(c <= restart_bound(SDR_LAT, SDR_HALF), "R4 sdram restart latency", c, restart_bound(SDR_LAT, SDR_HALF));
    step(60);
    sdr_stop_n = 1'b0;
    step(40);
    clear_counts();
    sdr_stop_n = 1'b1;
    step(2 * SDR_HALF);
    sdr_stop_n = 1'b0;
    step(200);
    chk(sdr_rc[0] == SDR_MIN, "R5 sdram minimum run", sdr_rc[0], SDR_MIN);

    // R6: mode 0 masks all requests (all three still asserted).
    mobile_mode = 1'b0;
    step(30);
    clear_counts();
    step(240);
    chk(cpu_rc[0] == exp_rises(240, CPU_HALF), "R6 cpu runs in mode 0", cpu_rc[0], exp_rises(240, CPU_HALF));
    chk(pci_rc[1] == exp_rises(240, PCI_HALF), "R6 pci runs in mode 0", pci_rc[1], exp_rises(240, PCI_HALF));
    chk(sdr_rc[0] == exp_rises(240, SDR_HALF), "R6 sdram runs in mode 0", sdr_rc[0], exp_rises(240, SDR_HALF));

    // R9: per-pin enables.
    cpu_en[1] = 1'b0;
    pci_en[0] = 1'b0;
    sdr_en[12] = 1'b0;
    step(20);
    clear_counts();
    step(120);
    chk(cpu_rc[1] == 0 && cpu_clk[1] == 1'b0, "R9 cpu pin disabled", cpu_rc[1], 0);
    chk(pci_rc[0] == 0 && pci_clk[0] == 1'b0, "R9 free pci pin disabled", pci_rc[0], 0);
    chk(sdr_rc[12] == 0 && sdr_clk[12] == 1'b0, "R9 sdram pin disabled", sdr_rc[12], 0);
    chk(cpu_rc[0] == exp_rises(120, CPU_HALF), "R9 neighbour cpu pin runs", cpu_rc[0], exp_rises(120, CPU_HALF));
    cpu_en = '1;
    pci_en = '1;
    sdr_en = '1;

    // R8: power-down, stop requests toggled meanwhile.
    mobile_mode = 1'b1;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    sdr_stop_n = 1'b1;
    step(40);
    pwrdn_n = 1'b0;
    step(SYNC + 2 * PCI_HALF + 1);
    chk((cpu_clk == '0) && (pci_clk == '0) && (sdr_clk == '0), "R8 outputs low after power-down",
        int'(cpu_clk) + int'(pci_clk) + int'(sdr_clk), 0);
    clear_counts();
    for (int k = 0; k < 10; k++) begin
      cpu_stop_n = 1'($urandom);
      pci_stop_n = 1'($urandom);
      sdr_stop_n = 1'($urandom);
      mobile_mode = 1'($urandom);
      step(20);
    end
    chk(total_rises() == 0, "R8 no edges during power-down", total_rises(), 0);
    mobile_mode = 1'b1;
    cpu_stop_n = 1'b1;
    pci_stop_n = 1'b1;
    sdr_stop_n = 1'b1;
    pwrdn_n = 1'b1;
    step(50);
    chk(cpu_rc[0] > 0 && pci_rc[0] > 0 && sdr_rc[0] > 0, "R8 restart after power-down", cpu_rc[0], 1);

    // Random phase: R3, R6, R7, R8 against the run function.
    for (int it = 0; it < 20; it++) begin
      m   = 1'($urandom);
      s_c = 1'($urandom);
      s_p = 1'($urandom);
      s_s = 1'($urandom);
      p   = ($urandom % 5) != 0;
      mobile_mode = m;
      cpu_stop_n = s_c;
      pci_stop_n = s_p;
      sdr_stop_n = s_s;
      pwrdn_n = p;
      step(520 + ($urandom % 200) - 48);
      clear_counts();
      step(48);
      chk(cpu_rc[0] == (exp_run(m, s_c, p) ? 12 : 0), "R3 R6 random cpu", cpu_rc[0], exp_run(m, s_c, p) ? 12 : 0);
      chk(pci_rc[1] == (exp_run(m, s_p, p) ? 4 : 0), "R3 R6 random pci", pci_rc[1], exp_run(m, s_p, p) ? 4 : 0);
      chk(pci_rc[0] == (p ? 4 : 0), "R7 R8 random free pci", pci_rc[0], p ? 4 : 0);
      chk(sdr_rc[0] == (exp_run(m, s_s, p) ? 12 : 0), "R3 R6 random sdram", sdr_rc[0], exp_run(m, s_s, p) ? 12 : 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule